// File: doc/BRIEF.md
# UART Receiver with Address Filter

This block is the receive half of an asynchronous serial port. It takes a serial line, a one-clock enable pulse at sixteen times the bit rate, and a few control inputs. From these it assembles frames of either 10 bits (start, 8 data bits, stop) or 11 bits (start, 8 data bits, a ninth bit, stop). Data arrive least significant bit first. The received byte and its ninth bit are held on outputs, and a receive-complete flag is raised. That flag stays set until it is cleared by a pulse on `ri_clr`. While the flag is set, new frames are dropped rather than written over the byte that has not been read.

Two optional features refine the receiver.

- **Framing check.** When enabled, every stop bit is checked. A low stop bit sets a sticky error flag. The receive-complete event also moves from the last data bit to the stop bit. While this feature is on, the top bit of the control byte reads and writes the error flag instead of the mode bit.
- **Multiprocessor filter.** When enabled, an address frame is accepted only if it matches the node's masked own address or the broadcast pattern derived from the address and mask. All other frames are dropped in hardware.

Top module: `uart_addr_rx`

## Requirements
- R1: In 8-bit format (`nine_bit`=0) with `mp_en`=0, a frame loads its 8 data bits, first bit received into bit 0, into `rx_data`. The sampled stop bit goes to `rx_bit9`, and `rx_done` is set.
- R2: In 9-bit format (`nine_bit`=1), the first 8 data bits go to `rx_data` and the ninth bit received goes to `rx_bit9`.
- R3: With `fe_en`=1, a stop bit sampled as 0 sets `fe_flag`. This applies in both frame formats.
- R4: `fe_flag` is sticky. A later frame with a valid stop bit leaves it set. It is cleared only by reset or by a write of 0 through `top_wr` while `fe_en`=1.
- R5: In 9-bit format with `fe_en`=0, `rx_done` is already set 8 clocks after the stop bit begins. With `fe_en`=1, `rx_done` is still 0 at that point and is set by the end of the stop bit.
- R6: `top_bit_rd` equals `fe_flag` when `fe_en`=1 and `mode_hi` otherwise. A `top_wr` while `fe_en`=0 leaves `fe_flag` unchanged.
- R7: In 9-bit format with `mp_en`=1, `rx_done` is raised only for a frame whose ninth bit is 1 and whose byte hits the own or broadcast address.
- R8: Own-address hit: every received bit where `addr_mask` is 1 equals the same bit of `own_addr`. Bits where the mask is 0 are ignored.
- R9: Broadcast hit: let P = `own_addr` | `addr_mask`. Every bit where P is 1 must be 1 in the received byte.
- R10: In 8-bit format with `mp_en`=1, `rx_done` is raised only when the address hits and the stop bit is 1.
- R11: Each bit is decided by a majority of three samples around mid-bit. A start bit that is not low at mid-bit is abandoned and produces no frame.
- R12: While `rx_done` is set, a new frame does not change `rx_data` or `rx_bit9`.
- R13: With `rx_en`=0, activity on `rxd` raises neither `rx_done` nor `fe_flag`.
- R14: After reset, `rx_done`, `fe_flag`, `rx_data` and `rx_bit9` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-clock enable pulse at 16x the bit rate |
| rxd | input | 1 | Serial input, idle high |
| nine_bit | input | 1 | 1 selects the 11-bit frame, 0 the 10-bit frame |
| mp_en | input | 1 | Multiprocessor address filter enable |
| fe_en | input | 1 | Framing check enable |
| rx_en | input | 1 | Receive enable |
| own_addr | input | 8 | Node address |
| addr_mask | input | 8 | Address mask (1 = compared bit) |
| mode_hi | input | 1 | Mode bit value that shares the top control bit |
| top_wr | input | 1 | Write strobe for the top control bit |
| top_wdata | input | 1 | Value written to the top control bit |
| ri_clr | input | 1 | Clears the receive-complete flag |
| rx_data | output | 8 | Last accepted byte |
| rx_bit9 | output | 1 | Ninth bit, or stop bit in 8-bit format |
| rx_done | output | 1 | Receive-complete flag |
| fe_flag | output | 1 | Sticky framing error flag |
| top_bit_rd | output | 1 | Read value of the top control bit |

## Verification
The line first passes through a two-stage synchronizer. A bit is then decided on the ninth oversample tick after its start, and the flags are registered one clock after that decision. With one tick every 4 clocks, a bit lasts 64 clocks and a result is due roughly 45 clocks into the bit that decides it. The bench therefore reads `rx_done` 8 clocks into the stop bit to separate the early and late flag positions. All other results are read 64 idle clocks after the stop bit ends, well clear of any decision edge. Inputs change and outputs are read on the falling clock edge.

// File: rtl/uarx_pkg.sv
package uarx_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        F_IDLE,
        F_START,
        F_DATA,
        F_STOP
    } frame_st_e;

    typedef struct packed {
        logic              data_evt;   // last data bit decided
        logic              stop_evt;   // stop bit decided
        logic              stop_val;   // sampled stop level
        logic [DATA_W:0]   bits;       // data bits, ninth bit on top
    } frame_ev_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic own_hit(input logic [DATA_W-1:0] rx,
                                     input logic [DATA_W-1:0] addr,
                                     input logic [DATA_W-1:0] mask);
        return ((rx ^ addr) & mask) == '0;
    endfunction

    function automatic logic bcast_hit(input logic [DATA_W-1:0] rx,
                                       input logic [DATA_W-1:0] addr,
                                       input logic [DATA_W-1:0] mask);
        logic [DATA_W-1:0] pat;
        pat = addr | mask;
        return (rx & pat) == pat;
    endfunction

endpackage

// File: rtl/uarx_sync.sv
module uarx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[STAGES-2:0], din};
    end

    assign dout = sh[STAGES-1];
endmodule

// File: rtl/uarx_addr_match.sv
module uarx_addr_match
    import uarx_pkg::*;
(
    input  logic [DATA_W-1:0] rx_byte,
    input  logic [DATA_W-1:0] own_addr,
    input  logic [DATA_W-1:0] addr_mask,
    output logic              hit
);
    logic own_h, bc_h;

    always_comb begin
        own_h = own_hit(rx_byte, own_addr, addr_mask);
        bc_h  = bcast_hit(rx_byte, own_addr, addr_mask);
        hit   = own_h | bc_h;
    end
endmodule

// File: rtl/uarx_frame.sv
module uarx_frame
    import uarx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      rx_s,
    input  logic      rx_en,
    input  logic      nine,
    output frame_ev_t ev
);
    localparam int CW = $clog2(OVS);
    localparam int IW = $clog2(DATA_W + 1);
    localparam logic [CW-1:0] SA   = CW'(OVS/2 - 1);
    localparam logic [CW-1:0] SB   = CW'(OVS/2);
    localparam logic [CW-1:0] SC   = CW'(OVS/2 + 1);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    frame_st_e       state;
    logic [CW-1:0]   cnt;
    logic [CW-1:0]   cnt_nx;
    logic [1:0]      smp;
    logic [IW-1:0]   idx;
    logic [IW-1:0]   idx_last;
    logic            nine_q;
    logic [DATA_W:0] bits;
    logic            dq, sq, svq;
    logic            vote;

    always_comb begin
        cnt_nx   = cnt + 1'b1;
        vote     = maj3(smp[1], smp[0], rx_s);
        idx_last = nine_q ? IW'(DATA_W) : IW'(DATA_W - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= F_IDLE;
            cnt    <= '0;
            smp    <= '0;
            idx    <= '0;
            nine_q <= 1'b0;
            bits   <= '0;
            dq     <= 1'b0;
            sq     <= 1'b0;
            svq    <= 1'b0;
        end else begin
            dq <= 1'b0;
            sq <= 1'b0;
            if (tick) begin
                if (state == F_IDLE) begin
                    if (rx_en && !rx_s) begin
                        state  <= F_START;
                        cnt    <= '0;
                        nine_q <= nine;
                    end
                end else begin
                    cnt <= cnt_nx;
                    if (cnt_nx == SA || cnt_nx == SB)
                        smp <= {smp[0], rx_s};
                    if (cnt_nx == SC) begin
                        case (state)
                            F_START: begin
                                if (vote) state <= F_IDLE;   // false start
                                idx  <= '0;
                                bits <= '0;
                            end
                            F_DATA: begin
                                bits[idx] <= vote;
                                if (idx == idx_last) dq <= 1'b1;
                            end
                            default: begin
                                sq    <= 1'b1;
                                svq   <= vote;
                                state <= F_IDLE;
                            end
                        endcase
                    end
                    if (cnt == LAST) begin
                        if (state == F_START) state <= F_DATA;
                        else if (state == F_DATA) begin
                            if (idx == idx_last) state <= F_STOP;
                            else idx <= idx + 1'b1;
                        end
                    end
                end
            end
        end
    end

    assign ev = '{data_evt: dq, stop_evt: sq, stop_val: svq, bits: bits};

    // R13
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == F_IDLE && !rx_en) |=> (state == F_IDLE));

    // R11
    stop_from_stop_chk: assert property (@(posedge clk) disable iff (rst)
        sq |-> $past(state == F_STOP));
endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx
    import uarx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick16,
    input  logic              rxd,
    input  logic              nine_bit,
    input  logic              mp_en,
    input  logic              fe_en,
    input  logic              rx_en,
    input  logic [DATA_W-1:0] own_addr,
    input  logic [DATA_W-1:0] addr_mask,
    input  logic              mode_hi,
    input  logic              top_wr,
    input  logic              top_wdata,
    input  logic              ri_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit9,
    output logic              rx_done,
    output logic              fe_flag,
    output logic              top_bit_rd
);
    logic      rx_s;
    frame_ev_t ev;
    logic      hit;
    logic      mp_ok9, mp_ok8, take, fe_set;
    logic      ri_q, fe_q;

    uarx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(rxd), .dout(rx_s)
    );

    uarx_frame #(.OVS(OVS)) u_frame (
        .clk(clk), .rst(rst), .tick(tick16), .rx_s(rx_s),
        .rx_en(rx_en), .nine(nine_bit), .ev(ev)
    );

    uarx_addr_match u_match (
        .rx_byte(ev.bits[DATA_W-1:0]), .own_addr(own_addr),
        .addr_mask(addr_mask), .hit(hit)
    );

    always_comb begin
        mp_ok9 = !mp_en || (ev.bits[DATA_W] && hit);
        mp_ok8 = !mp_en || (ev.stop_val && hit);
        take   = rx_en && !ri_q &&
                 ((ev.data_evt && nine_bit && !fe_en && mp_ok9) ||
                  (ev.stop_evt && (nine_bit ? (fe_en && mp_ok9) : mp_ok8)));
        fe_set = ev.stop_evt && fe_en && !ev.stop_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data <= '0;
            rx_bit9 <= 1'b0;
            ri_q    <= 1'b0;
            fe_q    <= 1'b0;
        end else begin
            if (take) begin
                rx_data <= ev.bits[DATA_W-1:0];
                rx_bit9 <= nine_bit ? ev.bits[DATA_W] : ev.stop_val;
                ri_q    <= 1'b1;
            end else if (ri_clr) begin
                ri_q <= 1'b0;
            end
            if (fe_set)                fe_q <= 1'b1;
            else if (top_wr && fe_en)  fe_q <= top_wdata;
        end
    end

    assign rx_done    = ri_q;
    assign fe_flag    = fe_q;
    assign top_bit_rd = fe_en ? fe_q : mode_hi;

    // R12
    no_overwrite_chk: assert property (@(posedge clk) disable iff (rst)
        (ri_q && !ri_clr) |=> $stable(rx_data));

    // R4
    fe_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (fe_q && !(top_wr && fe_en)) |=> fe_q);

    // R3
    fe_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fe_q) |-> ($past(ev.stop_evt && !ev.stop_val) || $past(top_wr && top_wdata)));

    // R7
    mp_filter_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(ri_q) && $past(mp_en && nine_bit)) |-> $past(hit && ev.bits[DATA_W]));

    // R5
    late_flag_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(ri_q) && $past(fe_en)) |-> $past(ev.stop_evt));
endmodule

// File: tb/uart_addr_rx_tb.sv
module uart_addr_rx_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic       nine_bit = 1'b0, mp_en = 1'b0, fe_en = 1'b0, rx_en = 1'b1;
    logic [7:0] own_addr = 8'hA3, addr_mask = 8'hF6;
    logic       mode_hi = 1'b0, top_wr = 1'b0, top_wdata = 1'b0, ri_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit9, rx_done, fe_flag, top_bit_rd;

    int n_chk = 0, n_bad = 0;
    int tdiv = 0;
    logic ri_probe;

    always #10 clk = ~clk;   // 50 MHz

    always @(negedge clk) begin
        tick16 <= (tdiv == 3);
        tdiv   <= (tdiv + 1) % 4;
    end

    uart_addr_rx u_dut (
        .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd), .nine_bit(nine_bit),
        .mp_en(mp_en), .fe_en(fe_en), .rx_en(rx_en), .own_addr(own_addr),
        .addr_mask(addr_mask), .mode_hi(mode_hi), .top_wr(top_wr),
        .top_wdata(top_wdata), .ri_clr(ri_clr), .rx_data(rx_data),
        .rx_bit9(rx_bit9), .rx_done(rx_done), .fe_flag(fe_flag),
        .top_bit_rd(top_bit_rd)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b);
        rxd = b;
        repeat (64) @(negedge clk);
    endtask

    task automatic send_frame(input logic [8:0] d, input logic nine, input logic stopv);
        drive_bit(1'b0);
        for (int i = 0; i < (nine ? 9 : 8); i++) drive_bit(d[i]);
        rxd = stopv;
        repeat (8) @(negedge clk);
        ri_probe = rx_done;
        repeat (56) @(negedge clk);
        rxd = 1'b1;
        repeat (64) @(negedge clk);
    endtask

    task automatic clear_ri;
        ri_clr = 1'b1; @(negedge clk); ri_clr = 1'b0; @(negedge clk);
    endtask

    task automatic write_top(input logic v);
        top_wdata = v; top_wr = 1'b1; @(negedge clk); top_wr = 1'b0; @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R14 rx_done", 16'(rx_done), 16'h0);
        chk("R14 fe_flag", 16'(fe_flag), 16'h0);
        chk("R14 rx_data", 16'(rx_data), 16'h0);
        chk("R14 rx_bit9", 16'(rx_bit9), 16'h0);
    endtask

    task automatic t_basic8;
        nine_bit = 0; mp_en = 0; fe_en = 0;
        send_frame(9'h0C5, 1'b0, 1'b1);
        chk("R1 done", 16'(rx_done), 16'h1);
        chk("R1 data", 16'(rx_data), 16'hC5);
        chk("R1 stop in bit9", 16'(rx_bit9), 16'h1);
        clear_ri();
        send_frame(9'h03A, 1'b0, 1'b0);
        chk("R1 data low stop", 16'(rx_data), 16'h3A);
        chk("R1 bit9 low stop", 16'(rx_bit9), 16'h0);
        clear_ri();
    endtask

    task automatic t_basic9;
        nine_bit = 1;
        send_frame(9'h15A, 1'b1, 1'b1);
        chk("R2 data", 16'(rx_data), 16'h5A);
        chk("R2 ninth", 16'(rx_bit9), 16'h1);
        clear_ri();
        send_frame(9'h0A5, 1'b1, 1'b1);
        chk("R2 ninth zero", 16'(rx_bit9), 16'h0);
        clear_ri();
    endtask

    task automatic t_ri_timing;
        nine_bit = 1; fe_en = 0;
        send_frame(9'h111, 1'b1, 1'b1);
        chk("R5 early flag", 16'(ri_probe), 16'h1);
        clear_ri();
        fe_en = 1;
        send_frame(9'h111, 1'b1, 1'b1);
        chk("R5 late flag probe", 16'(ri_probe), 16'h0);
        chk("R5 late flag end", 16'(rx_done), 16'h1);
        clear_ri();
    endtask

    task automatic t_fe;
        fe_en = 1; nine_bit = 0;
        send_frame(9'h042, 1'b0, 1'b0);
        chk("R3 fe 8-bit", 16'(fe_flag), 16'h1);
        clear_ri();
        write_top(1'b0);
        nine_bit = 1;
        send_frame(9'h142, 1'b1, 1'b0);
        chk("R3 fe 9-bit", 16'(fe_flag), 16'h1);
        clear_ri();
        send_frame(9'h077, 1'b1, 1'b1);
        chk("R4 sticky after good frame", 16'(fe_flag), 16'h1);
        clear_ri();
        write_top(1'b0);
        chk("R4 cleared by write", 16'(fe_flag), 16'h0);
    endtask

    task automatic t_topbit;
        fe_en = 1; write_top(1'b1);
        chk("R6 read fe", 16'(top_bit_rd), 16'h1);
        fe_en = 0; mode_hi = 0; @(negedge clk);
        chk("R6 read mode", 16'(top_bit_rd), 16'h0);
        write_top(1'b0);
        chk("R6 write ignored", 16'(fe_flag), 16'h1);
        fe_en = 1; write_top(1'b0);
        chk("R6 write applied", 16'(fe_flag), 16'h0);
        fe_en = 0;
    endtask

    task automatic t_mp9;
        nine_bit = 1; mp_en = 1; fe_en = 0;
        send_frame(9'h1AA, 1'b1, 1'b1);
        chk("R8 own hit", 16'(rx_done), 16'h1);
        chk("R8 own data", 16'(rx_data), 16'hAA);
        clear_ri();
        send_frame(9'h0AA, 1'b1, 1'b1);
        chk("R7 ninth zero dropped", 16'(rx_done), 16'h0);
        send_frame(9'h1A7, 1'b1, 1'b1);
        chk("R8 masked miss", 16'(rx_done), 16'h0);
        send_frame(9'h1FF, 1'b1, 1'b1);
        chk("R9 broadcast FF", 16'(rx_done), 16'h1);
        clear_ri();
        send_frame(9'h1F7, 1'b1, 1'b1);
        chk("R9 broadcast F7", 16'(rx_done), 16'h1);
        clear_ri();
        send_frame(9'h1FB, 1'b1, 1'b1);
        chk("R9 pattern miss", 16'(rx_done), 16'h0);
        mp_en = 0;
    endtask

    task automatic t_mp8;
        nine_bit = 0; mp_en = 1; fe_en = 0;
        send_frame(9'h0AA, 1'b0, 1'b1);
        chk("R10 hit good stop", 16'(rx_done), 16'h1);
        clear_ri();
        send_frame(9'h0AA, 1'b0, 1'b0);
        chk("R10 bad stop dropped", 16'(rx_done), 16'h0);
        send_frame(9'h0A7, 1'b0, 1'b1);
        chk("R10 miss dropped", 16'(rx_done), 16'h0);
        mp_en = 0;
    endtask

    task automatic t_false_start;
        nine_bit = 0;
        rxd = 0; repeat (16) @(negedge clk);
        rxd = 1; repeat (800) @(negedge clk);
        chk("R11 false start", 16'(rx_done), 16'h0);
        send_frame(9'h081, 1'b0, 1'b1);
        chk("R11 recovery", 16'(rx_data), 16'h81);
        clear_ri();
    endtask

    task automatic t_overwrite;
        nine_bit = 0;
        send_frame(9'h011, 1'b0, 1'b1);
        send_frame(9'h022, 1'b0, 1'b1);
        chk("R12 kept unread byte", 16'(rx_data), 16'h11);
        clear_ri();
    endtask

    task automatic t_rx_off;
        rx_en = 0; fe_en = 1; nine_bit = 0;
        send_frame(9'h099, 1'b0, 1'b0);
        chk("R13 no done", 16'(rx_done), 16'h0);
        chk("R13 no fe", 16'(fe_flag), 16'h0);
        rx_en = 1; fe_en = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R14 watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_basic8();
        t_basic9();
        t_ri_timing();
        t_fe();
        t_topbit();
        t_mp9();
        t_mp8();
        t_false_start();
        t_overwrite();
        t_rx_off();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule